// File: doc/BRIEF.md
# Compacting PC Breakpoint Table

This block holds a fixed number of breakpoint program-counter values and compares all of them against the PC of the instruction being executed. A slot that holds zero is empty. A debug controller installs a value through the add port. The block places it in the lowest empty slot and returns an acknowledge with a pass or fail flag one cycle later.

Removal is sequential. The block scans one slot per cycle. When it finds the first slot holding the requested value, that slot and every slot after it take the value of their upper neighbour, and the top slot is cleared. The occupied slots therefore always stay packed from slot 0 upward.

A global enable flag rises on any successful add. It is re-evaluated when a removal finishes. The hit output is a purely combinational function of the PC input, the table and the enable flag.

Top module: `bkpt_table`

## Requirements
- R1: After reset every slot is zero, and `enabled`, `busy`, `hit`, `add_ack` and `add_ok` are all 0.
- R2: An accepted add of a non-zero PC with a free slot stores it in the lowest-numbered zero slot. In the cycle after acceptance, `add_ack`=1 and `add_ok`=1.
- R3: An accepted add while all slots are non-zero returns `add_ack`=1 and `add_ok`=0, and the table does not change.
- R4: An accepted add of PC value 0 returns `add_ack`=1 and `add_ok`=0, and the table does not change.
- R5: A successful add sets `enabled` to 1 in the cycle after acceptance.
- R6: `hit` is 1 exactly when `enabled`=1 and some non-zero slot equals `pc_in`. It follows `pc_in` with no register in the path.
- R7: An accepted remove keeps `busy` high for NUM_SLOTS+1 cycles. Scan step k handles slot k. The first slot equal to the non-zero target, and every later slot, take the value of the next slot. The top slot takes zero. Later copies of the same value stay in the table.
- R8: In the last cycle of a remove, `enabled` becomes 1 if any slot is non-zero and 0 otherwise.
- R9: A remove of a value that is absent from the table, or of value 0, leaves every slot unchanged.
- R10: While `busy`=1, no add or remove is accepted, and `add_ack` stays 0 in the following cycle. A requester keeps its request raised until it is served.
- R11: An add is accepted only when `add_req`=1, `busy`=0 and `rm_req`=0. When both requests arrive together while idle, the remove is taken and the add waits.
- R12: Occupied slots are contiguous from slot 0: no non-zero slot sits above a zero slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| add_req | input | 1 | Request to install `add_pc` |
| add_pc | input | PC_W | PC value to install |
| add_ack | output | 1 | One-cycle pulse: an add was accepted on the previous edge |
| add_ok | output | 1 | Valid with `add_ack`: 1 when the value was stored |
| rm_req | input | 1 | Request to remove `rm_pc` |
| rm_pc | input | PC_W | PC value to remove |
| busy | output | 1 | A remove sequence is in progress |
| pc_in | input | PC_W | PC of the executing instruction |
| hit | output | 1 | `pc_in` matches an installed breakpoint |
| enabled | output | 1 | Global breakpoint enable flag |

## Verification
Some properties are checked by assertions on every cycle:
- slot packing (no non-zero slot above a zero slot);
- `hit` never asserting without `enabled`;
- an idle, disabled table being all zero;
- a table that stays unchanged after a rejected add into a full table;
- no acknowledge following a busy cycle;
- the scan index staying in range.

Other behaviour is visible only through the bench scenarios, which compare `hit` against a queue model on every cycle:
- which value a remove takes out (the first copy only, at scan step k);
- a removed value vanishing from `hit` only at its scan step;
- the freed space being reusable;
- a remove winning over a simultaneous add.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SCAN   = 2'd1,
    PH_SETTLE = 2'd2
  } rm_phase_e;
endpackage

// File: rtl/bkpt_alloc.sv
module bkpt_alloc #(
  parameter int NUM_SLOTS = 4,
  localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic [NUM_SLOTS-1:0] used_vec,
  output logic [IDX_W-1:0]     free_idx,
  output logic                 full
);
  function automatic logic [IDX_W-1:0] lowest_clear(input logic [NUM_SLOTS-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (!v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  assign free_idx = lowest_clear(used_vec);
  assign full     = &used_vec;
endmodule

// File: rtl/bkpt_match.sv
module bkpt_match #(
  parameter int NUM_SLOTS = 4,
  parameter int PC_W      = 32
) (
  input  logic [NUM_SLOTS*PC_W-1:0] tab_flat,
  input  logic [PC_W-1:0]           pc_in,
  input  logic                      enable,
  output logic                      hit
);
  function automatic logic slot_hits(input logic [PC_W-1:0] slot_val,
                                     input logic [PC_W-1:0] pc);
    return (slot_val != '0) && (slot_val == pc);
  endfunction

  logic [NUM_SLOTS-1:0] eq_vec;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_cmp
    assign eq_vec[g] = slot_hits(tab_flat[g*PC_W +: PC_W], pc_in);
  end

  assign hit = enable && (|eq_vec);
endmodule

// File: rtl/bkpt_rm_seq.sv
module bkpt_rm_seq
  import bkpt_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int PC_W      = 32,
  localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [PC_W-1:0]  target,
  input  logic [PC_W-1:0]  cur_val,
  output logic             busy,
  output logic [IDX_W-1:0] step_idx,
  output logic             shift_en,
  output logic             settle
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SLOTS - 1);

  function automatic logic is_target(input logic [PC_W-1:0] v,
                                     input logic [PC_W-1:0] t);
    return (t != '0) && (v == t);
  endfunction

  rm_phase_e        phase;
  logic [IDX_W-1:0] idx;
  logic             found;
  logic [PC_W-1:0]  tgt;
  logic             here;

  assign here     = (phase == PH_SCAN) && !found && is_target(cur_val, tgt);
  assign shift_en = (phase == PH_SCAN) && (found || here);
  assign settle   = (phase == PH_SETTLE);
  assign busy     = (phase != PH_IDLE);
  assign step_idx = idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      idx   <= '0;
      found <= 1'b0;
      tgt   <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (start) begin
          phase <= PH_SCAN;
          idx   <= '0;
          found <= 1'b0;
          tgt   <= target;
        end
        PH_SCAN: begin
          if (here) found <= 1'b1;
          if (idx == LAST_IDX) phase <= PH_SETTLE;
          else idx <= idx + 1'b1;
        end
        PH_SETTLE: phase <= PH_IDLE;
        default:   phase <= PH_IDLE;
      endcase
    end
  end

  // R7
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (step_idx <= LAST_IDX));

  // R7
  scan_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SCAN && idx == LAST_IDX) |=> settle);

  // R10
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !settle) |=> busy);
endmodule

// File: rtl/bkpt_table.sv
module bkpt_table #(
  parameter int NUM_SLOTS = 4,
  parameter int PC_W      = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            add_req,
  input  logic [PC_W-1:0] add_pc,
  output logic            add_ack,
  output logic            add_ok,
  input  logic            rm_req,
  input  logic [PC_W-1:0] rm_pc,
  output logic            busy,
  input  logic [PC_W-1:0] pc_in,
  output logic            hit,
  output logic            enabled
);
  localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  logic [PC_W-1:0]           slot_q [NUM_SLOTS];
  logic [NUM_SLOTS*PC_W-1:0] tab_flat;
  logic [NUM_SLOTS-1:0]      used_vec;
  logic [IDX_W-1:0]          free_idx;
  logic                      full;
  logic                      add_fire;
  logic                      add_good;
  logic                      rm_fire;
  logic [IDX_W-1:0]          step_idx;
  logic                      shift_en;
  logic                      settle;
  logic [PC_W-1:0]           cur_val;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_view
    assign tab_flat[g*PC_W +: PC_W] = slot_q[g];
    assign used_vec[g]              = (slot_q[g] != '0);
  end

  assign rm_fire  = rm_req && !busy;
  assign add_fire = add_req && !busy && !rm_req;
  assign add_good = add_fire && (add_pc != '0) && !full;
  assign cur_val  = slot_q[step_idx];

  bkpt_alloc #(.NUM_SLOTS(NUM_SLOTS)) i_alloc (
    .used_vec (used_vec),
    .free_idx (free_idx),
    .full     (full)
  );

  bkpt_rm_seq #(.NUM_SLOTS(NUM_SLOTS), .PC_W(PC_W)) i_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (rm_fire),
    .target   (rm_pc),
    .cur_val  (cur_val),
    .busy     (busy),
    .step_idx (step_idx),
    .shift_en (shift_en),
    .settle   (settle)
  );

  bkpt_match #(.NUM_SLOTS(NUM_SLOTS), .PC_W(PC_W)) i_match (
    .tab_flat (tab_flat),
    .pc_in    (pc_in),
    .enable   (enabled),
    .hit      (hit)
  );

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic [PC_W-1:0] upper;
    if (g == NUM_SLOTS - 1) begin : g_top
      assign upper = '0;
    end else begin : g_mid
      assign upper = slot_q[g+1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[g] <= '0;
      end else if (add_good && free_idx == IDX_W'(g)) begin
        slot_q[g] <= add_pc;
      end else if (shift_en && step_idx == IDX_W'(g)) begin
        slot_q[g] <= upper;
      end
    end

    if (g < NUM_SLOTS - 1) begin : g_pack
      // R12
      packed_slots_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q[g] == '0) |-> (slot_q[g+1] == '0));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enabled <= 1'b0;
      add_ack <= 1'b0;
      add_ok  <= 1'b0;
    end else begin
      add_ack <= add_fire;
      add_ok  <= add_good;
      if (add_good)    enabled <= 1'b1;
      else if (settle) enabled <= |used_vec;
    end
  end

  // R6
  hit_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> enabled);

  // R3
  full_add_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (add_fire && full) |=> $stable(tab_flat));

  // R5
  add_enables_chk: assert property (@(posedge clk) disable iff (!rst_n)
    add_good |=> enabled);

  // R10
  no_ack_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !add_ack);

  // R8
  disabled_is_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !enabled) |-> (tab_flat == '0));

  // R2
  ok_implies_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    add_ok |-> add_ack);
endmodule

// File: tb/test_bkpt_table.sv
module test_bkpt_table;
  localparam int N    = 4;
  localparam int PC_W = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            add_req = 1'b0;
  logic [PC_W-1:0] add_pc = '0;
  logic            rm_req = 1'b0;
  logic [PC_W-1:0] rm_pc = '0;
  logic [PC_W-1:0] pc_in = '0;
  logic            add_ack, add_ok, busy, hit, enabled;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [PC_W-1:0] q[$];
  bit m_en = 0, m_busy = 0, m_ack = 0, m_ok = 0;
  int s = 0, k = -1;

  always #4 clk = ~clk;

  bkpt_table #(.NUM_SLOTS(N), .PC_W(PC_W)) i_bkpt_table (
    .clk(clk), .rst_n(rst_n), .add_req(add_req), .add_pc(add_pc),
    .add_ack(add_ack), .add_ok(add_ok), .rm_req(rm_req), .rm_pc(rm_pc),
    .busy(busy), .pc_in(pc_in), .hit(hit), .enabled(enabled)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit model_hit(input logic [PC_W-1:0] p);
    if (!m_en || p == '0) return 0;
    foreach (q[i]) if (q[i] == p) return 1;
    return 0;
  endfunction

  task automatic model_edge(input bit a, input logic [PC_W-1:0] apc,
                            input bit r, input logic [PC_W-1:0] rpc);
    m_ack = 0; m_ok = 0;
    if (m_busy) begin
      s++;
      if (k >= 0 && s == k + 1) q.delete(k);
      if (s == N + 1) begin m_busy = 0; m_en = (q.size() > 0); end
    end else if (r) begin
      m_busy = 1; s = 0; k = -1;
      if (rpc != '0) begin
        for (int i = 0; i < q.size(); i++) if (k < 0 && q[i] == rpc) k = i;
      end
    end else if (a) begin
      m_ack = 1;
      if (apc != '0 && q.size() < N) begin
        q.push_back(apc); m_en = 1; m_ok = 1;
      end
    end
  endtask

  task automatic compare(input string req);
    check(req, "hit", hit, model_hit(pc_in));
    check(req, "enabled", enabled, m_en);
    check(req, "busy", busy, m_busy);
    check(req, "add_ack", add_ack, m_ack);
    check(req, "add_ok", add_ok, m_ok);
  endtask

  task automatic step(input string req, input bit a, input logic [PC_W-1:0] apc,
                      input bit r, input logic [PC_W-1:0] rpc, input logic [PC_W-1:0] probe);
    add_req = a; add_pc = apc; rm_req = r; rm_pc = rpc; pc_in = probe;
    @(posedge clk);
    model_edge(a, apc, r, rpc);
    @(negedge clk);
    compare(req);
    // combinational path: change pc_in away from the edge and re-check hit
    pc_in = probe ^ 32'h0000_0004;
    #1;
    check({req, " R6"}, "hit_comb", hit, model_hit(pc_in));
    pc_in = probe;
  endtask

  task automatic drain(input string req, input logic [PC_W-1:0] probe);
    while (m_busy) step(req, 0, '0, 0, '0, probe);
    step(req, 0, '0, 0, '0, probe);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    step("R1", 0, '0, 0, '0, 32'h100);

    step("R2", 1, 32'h100, 0, '0, 32'h100);
    step("R5", 1, 32'h200, 0, '0, 32'h200);
    step("R6", 0, '0, 0, '0, 32'h300);
    step("R4", 1, 32'h0, 0, '0, 32'h0);
    step("R2", 1, 32'h300, 0, '0, 32'h300);
    step("R2", 1, 32'h400, 0, '0, 32'h400);
    step("R3", 1, 32'h500, 0, '0, 32'h500);
    step("R3", 0, '0, 0, '0, 32'h100);

    // remove a middle entry; hold an add request during busy
    step("R7", 0, '0, 1, 32'h200, 32'h200);
    for (int i = 0; i < N + 1; i++)
      step("R10", (m_busy ? 1'b1 : 1'b0), 32'h500, 0, '0, (i % 2) ? 32'h200 : 32'h400);
    step("R12", 1, 32'h500, 0, '0, 32'h500);
    step("R12", 0, '0, 0, '0, 32'h400);

    // absent value and zero target
    step("R9", 0, '0, 1, 32'h999, 32'h300);
    drain("R9", 32'h100);
    step("R9", 0, '0, 1, 32'h0, 32'h500);
    drain("R9", 32'h300);

    // simultaneous requests: remove wins
    step("R11", 1, 32'h600, 1, 32'h100, 32'h100);
    drain("R11", 32'h100);
    step("R11", 0, '0, 0, '0, 32'h600);

    // duplicate values: only the first copy leaves
    step("R7", 1, 32'h300, 0, '0, 32'h300);
    step("R7", 0, '0, 1, 32'h300, 32'h300);
    drain("R7", 32'h300);

    // empty the table
    step("R8", 0, '0, 1, 32'h300, 32'h300); drain("R8", 32'h300);
    step("R8", 0, '0, 1, 32'h400, 32'h400); drain("R8", 32'h400);
    step("R8", 0, '0, 1, 32'h500, 32'h500); drain("R8", 32'h500);
    step("R8", 0, '0, 0, '0, 32'h500);

    // refill after empty
    step("R5", 1, 32'h700, 0, '0, 32'h700);
    step("R6", 0, '0, 0, '0, 32'h700);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule